// File: doc/BRIEF.md
# Alternating Transmit Buffer Status Controller

This block manages the status of two transmit buffers that one serial channel with asynchronous HDLC/PPP framing uses in turn. Each buffer has a host-writable status byte. The host fills a buffer, sets its ownership bit and so hands it to the transmitter. The block keeps track of which buffer is current. When the data path reports that the current buffer has been sent, the block returns the buffer to the host by clearing ownership and records end-of-buffer and any bus error in that buffer's byte.

At the same point the block raises a one-cycle interrupt pulse if the buffer asked for one. It also raises a one-cycle frame-end pulse if the buffer was marked as the last of its frame, so that the framer can close the frame. For the current buffer it drives a map-all flag that tells the character escaper to escape every control character instead of consulting its normal escape table. Buffer A is used first. The block then moves to the next buffer and waits until the host has handed that buffer over.

Top module: `tx_bufstat_ctrl`

## Requirements
- R1: After reset both status bytes read 0x00, buf_cur_o is 0 (buffer A), and buf_valid_o, map_all_o, irq_o and frame_end_o are 0.
- R2: Status byte bits 4 and 3 always read 0, whatever the host writes.
- R3: A host write sets bit 6 (end-of-frame), bit 2 (map-all) and bit 1 (interrupt request) to the written values. Writing 1 to bit 0 (ownership) sets it. Writing 0 to bit 0 leaves it unchanged.
- R4: Bit 7 (bus error) and bit 5 (end-of-buffer) are cleared by a host write of 0 and unchanged by a host write of 1.
- R5: Buffers are used alternately, starting with A (buf_cur_o = 0; B is 1). buf_valid_o equals the ownership bit of the current buffer.
- R6: A pulse on xfer_done_i while buf_valid_o is 1 completes the current buffer. From the next edge on, that buffer's ownership bit is 0, its end-of-buffer bit is 1, its bus-error bit is 1 if bus_err_i was 1 with the done pulse, and buf_cur_o points to the other buffer.
- R7: irq_o is high for exactly the cycle after a completion, and only if the completed buffer's interrupt-request bit was 1.
- R8: frame_end_o is high for exactly the cycle after a completion, and only if the completed buffer's end-of-frame bit was 1.
- R9: map_all_o equals the map-all bit of the current buffer.
- R10: xfer_done_i while buf_valid_o is 0 has no effect. buf_cur_o and both status bytes stay unchanged, and no pulse appears.
- R11: When a host write and a completion hit the same buffer in the same cycle, the device's update wins: ownership ends 0 and end-of-buffer ends 1. The pulses follow the bits that held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_wsel_i | input | SEL_W | Buffer selected for the write (0 = A, 1 = B) |
| host_wdata_i | input | 8 | Status byte written by the host |
| host_rsel_i | input | SEL_W | Buffer selected for the read |
| host_rdata_o | output | 8 | Status byte of the selected buffer |
| xfer_done_i | input | 1 | Data path reached the end of the current buffer |
| bus_err_i | input | 1 | Bus error seen on the transfer, qualified by xfer_done_i |
| buf_cur_o | output | SEL_W | Index of the current buffer |
| buf_valid_o | output | 1 | Current buffer is owned by the device |
| map_all_o | output | 1 | Escape all control characters for the current buffer |
| irq_o | output | 1 | Interrupt pulse after a completion |
| frame_end_o | output | 1 | Frame-end pulse after a completion |

## Verification
Completions are driven under several conditions. Done pulses arrive while the next buffer is not yet owned, which shows the stall. Completions carry and lack a bus error, which separates bus-error recording from end-of-buffer recording. Buffers mark interrupt-only, frame-end-only, or both, which shows that the two pulses are decoded independently. Back-to-back completions on consecutive cycles show the alternation without a gap. Host writes of all ones and all zeros separate the set-only, clear-only and plain-written bits, and a write that collides with a completion shows that the device update wins.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef struct packed {
    logic berr;
    logic eof;
    logic eob;
    logic map_all;
    logic irq_req;
    logic own;
  } buf_stat_t;

  // byte positions; the host decodes these
  localparam int unsigned B_OWN  = 0;
  localparam int unsigned B_IRQ  = 1;
  localparam int unsigned B_MAP  = 2;
  localparam int unsigned B_EOB  = 5;
  localparam int unsigned B_EOF  = 6;
  localparam int unsigned B_BERR = 7;

  function automatic logic [7:0] stat_pack(buf_stat_t s);
    logic [7:0] b;
    b         = 8'h00;
    b[B_BERR] = s.berr;
    b[B_EOF]  = s.eof;
    b[B_EOB]  = s.eob;
    b[B_MAP]  = s.map_all;
    b[B_IRQ]  = s.irq_req;
    b[B_OWN]  = s.own;
    return b;
  endfunction

endpackage

// File: rtl/tbs_stat_reg.sv
module tbs_stat_reg
  import tbs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic [7:0] wdata_i,
  input  logic      done_i,
  input  logic      berr_i,
  output buf_stat_t stat_o
);

  buf_stat_t stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_i) begin
      stat_d.eof     = wdata_i[B_EOF];
      stat_d.map_all = wdata_i[B_MAP];
      stat_d.irq_req = wdata_i[B_IRQ];
      if (wdata_i[B_OWN])   stat_d.own  = 1'b1;
      if (!wdata_i[B_BERR]) stat_d.berr = 1'b0;
      if (!wdata_i[B_EOB])  stat_d.eob  = 1'b0;
    end
    // device update applied last so it wins a same-cycle collision
    if (done_i) begin
      stat_d.own = 1'b0;
      stat_d.eob = 1'b1;
      if (berr_i) stat_d.berr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/tbs_sequencer.sv
module tbs_sequencer #(
  parameter int unsigned NBUF  = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             cur_own_i,
  input  logic             cur_irq_i,
  input  logic             cur_eof_i,
  output logic [SEL_W-1:0] cur_o,
  output logic             fire_o,
  output logic             irq_o,
  output logic             frame_end_o
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(NBUF - 1);

  logic [SEL_W-1:0] cur_q;
  logic             irq_q, fe_q;
  logic             fire;

  assign fire = done_i & cur_own_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      irq_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      irq_q <= fire & cur_irq_i;
      fe_q  <= fire & cur_eof_i;
      if (fire) cur_q <= (cur_q == LAST) ? '0 : cur_q + SEL_W'(1);
    end
  end

  assign cur_o       = cur_q;
  assign fire_o      = fire;
  assign irq_o       = irq_q;
  assign frame_end_o = fe_q;

endmodule

// File: rtl/tx_bufstat_ctrl.sv
module tx_bufstat_ctrl
  import tbs_pkg::*;
#(
  parameter  int unsigned NBUF  = 2,
  localparam int unsigned SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [SEL_W-1:0] host_wsel_i,
  input  logic [7:0]       host_wdata_i,
  input  logic [SEL_W-1:0] host_rsel_i,
  output logic [7:0]       host_rdata_o,
  input  logic             xfer_done_i,
  input  logic             bus_err_i,
  output logic [SEL_W-1:0] buf_cur_o,
  output logic             buf_valid_o,
  output logic             map_all_o,
  output logic             irq_o,
  output logic             frame_end_o
);

  buf_stat_t        stat[NBUF];
  buf_stat_t        cur_stat;
  logic [SEL_W-1:0] cur;
  logic             fire;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    tbs_stat_reg i_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (host_we_i && (host_wsel_i == SEL_W'(g))),
      .wdata_i(host_wdata_i),
      .done_i (fire && (cur == SEL_W'(g))),
      .berr_i (bus_err_i),
      .stat_o (stat[g])
    );
  end

  always_comb begin
    cur_stat = '0;
    for (int i = 0; i < NBUF; i++)
      if (cur == SEL_W'(i)) cur_stat = stat[i];
  end

  always_comb begin
    host_rdata_o = 8'h00;
    for (int i = 0; i < NBUF; i++)
      if (host_rsel_i == SEL_W'(i)) host_rdata_o = stat_pack(stat[i]);
  end

  tbs_sequencer #(.NBUF(NBUF), .SEL_W(SEL_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (xfer_done_i),
    .cur_own_i  (cur_stat.own),
    .cur_irq_i  (cur_stat.irq_req),
    .cur_eof_i  (cur_stat.eof),
    .cur_o      (cur),
    .fire_o     (fire),
    .irq_o      (irq_o),
    .frame_end_o(frame_end_o)
  );

  assign buf_cur_o   = cur;
  assign buf_valid_o = cur_stat.own;
  assign map_all_o   = cur_stat.map_all;

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int unsigned SEL_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       host_rdata_o,
  input logic             xfer_done_i,
  input logic [SEL_W-1:0] buf_cur_o,
  input logic             buf_valid_o,
  input logic             irq_o,
  input logic             frame_end_o
);

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o[4:3] == 2'b00); // R2

  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && buf_valid_o) |=> (buf_cur_o != $past(buf_cur_o))); // R5

  AST_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_done_i && buf_valid_o) |=> $stable(buf_cur_o)); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(xfer_done_i && buf_valid_o)); // R7

  AST_FE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> $past(xfer_done_i && buf_valid_o)); // R8

endmodule

bind tx_bufstat_ctrl tbs_checker #(.SEL_W(SEL_W)) i_tbs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_rdata_o(host_rdata_o),
  .xfer_done_i (xfer_done_i),
  .buf_cur_o   (buf_cur_o),
  .buf_valid_o (buf_valid_o),
  .irq_o       (irq_o),
  .frame_end_o (frame_end_o)
);

// File: tb/test_tx_bufstat_ctrl.sv
module test_tx_bufstat_ctrl;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_we_i = 1'b0;
  logic [0:0] host_wsel_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [0:0] host_rsel_i = '0;
  logic [7:0] host_rdata_o;
  logic       xfer_done_i = 1'b0;
  logic       bus_err_i = 1'b0;
  logic [0:0] buf_cur_o;
  logic       buf_valid_o, map_all_o, irq_o, frame_end_o;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  typedef struct packed { logic irq; logic fe; } ev_t;
  ev_t exp_q[$];

  always #10 clk = ~clk;

  tx_bufstat_ctrl i_tx_bufstat_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_we_i(host_we_i), .host_wsel_i(host_wsel_i), .host_wdata_i(host_wdata_i),
    .host_rsel_i(host_rsel_i), .host_rdata_o(host_rdata_o),
    .xfer_done_i(xfer_done_i), .bus_err_i(bus_err_i),
    .buf_cur_o(buf_cur_o), .buf_valid_o(buf_valid_o), .map_all_o(map_all_o),
    .irq_o(irq_o), .frame_end_o(frame_end_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic sel, logic [7:0] exp, string req);
    host_rsel_i = sel;
    #1;
    chk(req, host_rdata_o, exp);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    host_we_i = 1'b1; host_wsel_i = sel; host_wdata_i = d;
    @(negedge clk);
    host_we_i = 1'b0;
  endtask

  // expected events pushed here, popped by the monitor
  task automatic complete(logic berr, logic irq, logic fe);
    @(negedge clk);
    if (irq || fe) exp_q.push_back('{irq: irq, fe: fe});
    xfer_done_i = 1'b1; bus_err_i = berr;
    @(negedge clk);
    xfer_done_i = 1'b0; bus_err_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_ni && (irq_o || frame_end_o)) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R7/R8 unexpected pulse: actual irq=%0b fe=%0b expected none", irq_o, frame_end_o);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk("R7 irq pulse", {7'd0, irq_o}, {7'd0, e.irq});
        chk("R8 frame_end pulse", {7'd0, frame_end_o}, {7'd0, e.fe});
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, 8'h00, "R1 A reset");
    rd(1, 8'h00, "R1 B reset");
    chk("R1 cur", {7'd0, buf_cur_o}, 8'h00);
    chk("R1 valid/map/irq/fe", {4'd0, buf_valid_o, map_all_o, irq_o, frame_end_o}, 8'h00);

    // R10 done with nothing owned
    complete(1'b1, 1'b0, 1'b0);
    chk("R10 cur unchanged", {7'd0, buf_cur_o}, 8'h00);
    rd(0, 8'h00, "R10 A unchanged");

    // R2 R3 R4 write all ones to A
    wr(0, 8'hFF);
    rd(0, 8'h47, "R2/R3/R4 A after 0xFF");
    chk("R5 valid follows A own", {7'd0, buf_valid_o}, 8'h01);
    chk("R9 map_all of A", {7'd0, map_all_o}, 8'h01);
    wr(1, 8'h02);
    rd(1, 8'h02, "R3 B irq only");
    wr(0, 8'h46);
    rd(0, 8'h47, "R3 own not cleared by host");

    // R6 complete A with bus error, irq and eof
    complete(1'b1, 1'b1, 1'b1);
    rd(0, 8'hE6, "R6 A after completion");
    chk("R5 cur to B", {7'd0, buf_cur_o}, 8'h01);
    chk("R5 stall on B", {7'd0, buf_valid_o}, 8'h00);
    chk("R9 map_all of B", {7'd0, map_all_o}, 8'h00);

    // R10 stall, done ignored
    complete(1'b0, 1'b0, 1'b0);
    chk("R10 cur held", {7'd0, buf_cur_o}, 8'h01);
    rd(1, 8'h02, "R10 B unchanged");

    // R4 ones keep sticky bits, zeros clear them
    wr(0, 8'hFF);
    rd(0, 8'hE7, "R4 ones keep berr/eob");
    wr(0, 8'h47);
    rd(0, 8'h47, "R4 zeros clear berr/eob");

    // B eof-only completes, back to A
    wr(1, 8'h41);
    complete(1'b0, 1'b0, 1'b1);
    rd(1, 8'h60, "R6 B after completion");
    chk("R5 cur back to A", {7'd0, buf_cur_o}, 8'h00);
    chk("R5 A valid", {7'd0, buf_valid_o}, 8'h01);

    // R11 collision on A
    @(negedge clk);
    exp_q.push_back('{irq: 1'b1, fe: 1'b1});
    host_we_i = 1'b1; host_wsel_i = 1'b0; host_wdata_i = 8'h07;
    xfer_done_i = 1'b1;
    @(negedge clk);
    host_we_i = 1'b0; xfer_done_i = 1'b0;
    rd(0, 8'h26, "R11 device wins");
    chk("R11 cur to B", {7'd0, buf_cur_o}, 8'h01);

    // R5 back-to-back completions B then A
    wr(1, 8'h03);
    wr(0, 8'h03);
    @(negedge clk);
    exp_q.push_back('{irq: 1'b1, fe: 1'b0});
    exp_q.push_back('{irq: 1'b1, fe: 1'b0});
    xfer_done_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    xfer_done_i = 1'b0;
    rd(1, 8'h22, "R6 B back-to-back");
    rd(0, 8'h22, "R6 A back-to-back");
    chk("R5 cur after two", {7'd0, buf_cur_o}, 8'h01);

    repeat (3) @(negedge clk);
    chk("R7/R8 all pulses seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule